// File: doc/BRIEF.md
# Register-File ALU Execute Stage

This block is the arithmetic/logic execute stage of a small 16-bit load/store processor. A 16-bit instruction word is presented together with a valid strobe and captured into an internal instruction register. On the following clock edge the stage decodes the captured word, reads up to two of its eight general registers, performs an addition, a bitwise AND or a bitwise inversion, writes the result to a destination register, and updates three condition flags (negative, zero, positive) from that result.

The second operand of ADD and AND comes either from a register or from a 5-bit two's-complement immediate held in the instruction. A single mode bit selects between them. The immediate is sign-extended to 16 bits. A debug read port exposes any register by index, and the three flags are driven directly as outputs. Words whose opcode is not one of the three supported operations are ignored.

Top module: `alu_exec_stage`

## Requirements
- R1: Synchronous active-high reset clears all eight registers to 0x0000, sets the zero flag and clears the negative and positive flags.
- R2: Opcode bits [15:12] = 4'b0001 with bit 5 = 0 writes reg[bits 11:9] = reg[bits 8:6] + reg[bits 2:0] (modulo 2^16); bits 4:3 have no effect.
- R3: Opcode 4'b0001 with bit 5 = 1 adds the immediate in bits 4:0, sign-extended from bit 4, so the added value ranges from -16 to +15.
- R4: Opcode 4'b0101 performs a bitwise AND with the same register form (bit 5 = 0, second source in bits 2:0) and immediate form (bit 5 = 1, sign-extended bits 4:0) as R2 and R3.
- R5: Opcode 4'b1001 with bits 5:0 = 6'b111111 writes reg[bits 11:9] = ~reg[bits 8:6]. Any other value in bits 5:0 makes the word illegal, so no register and no flag changes.
- R6: Every register write sets N when bit 15 of the result is 1, sets Z when the result is 0, and sets P otherwise. Exactly one flag is 1 at all times.
- R7: A word is captured on the rising edge at which the valid input is high. Its register write and flag update appear together on the next rising edge, and no state changes at the capturing edge.
- R8: A word with any opcode other than 0001, 0101 or 1001, or any word presented while valid is low, changes no register and no flag.
- R9: Words may be presented on consecutive cycles. Each word sees the results of all earlier words, and a destination may equal a source register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | Strobe: capture `instr` at this edge |
| instr | input | 16 | Instruction word |
| dbg_sel | input | 3 | Register index for the debug read port |
| dbg_data | output | 16 | Contents of the register selected by `dbg_sel` |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_p | output | 1 | Positive flag |

## Verification
On every cycle, the assertions check four things: exactly one flag is set, the flags follow the value most recently written, a captured word always reaches execution on the next edge, and a register write lands in the register it addresses. They also check that the flags hold steady whenever nothing is written and that the zero flag is set straight after reset. The directed scenarios are needed to show that the arithmetic itself is correct: sign extension at the ends of the immediate range, the ignored bits 4:3, illegal NOT patterns and unsupported opcodes, and back-to-back words that depend on each other.

// File: rtl/alu_exec_pkg.sv
package alu_exec_pkg;

    localparam int DATA_W  = 16;
    localparam int NUM_REG = 8;
    localparam int REG_AW  = $clog2(NUM_REG);
    localparam int IMM_W   = 5;

    localparam logic [3:0] OPC_ADD = 4'b0001;
    localparam logic [3:0] OPC_AND = 4'b0101;
    localparam logic [3:0] OPC_INV = 4'b1001;

    typedef enum logic [1:0] {
        OP_NONE = 2'd0,
        OP_ADD  = 2'd1,
        OP_AND  = 2'd2,
        OP_INV  = 2'd3
    } alu_op_e;

    typedef struct packed {
        alu_op_e             op;
        logic                use_imm;
        logic [REG_AW-1:0]   dst;
        logic [REG_AW-1:0]   src_a;
        logic [REG_AW-1:0]   src_b;
        logic [DATA_W-1:0]   imm;
    } dec_t;

    typedef struct packed {
        logic n;
        logic z;
        logic p;
    } cc_t;

    localparam cc_t CC_RESET = '{n: 1'b0, z: 1'b1, p: 1'b0};

    function automatic logic [DATA_W-1:0] sext_imm(input logic [IMM_W-1:0] raw);
        return {{(DATA_W-IMM_W){raw[IMM_W-1]}}, raw};
    endfunction

    function automatic cc_t cc_from(input logic [DATA_W-1:0] value);
        cc_t c;
        c.n = value[DATA_W-1];
        c.z = (value == '0);
        c.p = !value[DATA_W-1] && (value != '0);
        return c;
    endfunction

endpackage

// File: rtl/alu_decode.sv
module alu_decode
    import alu_exec_pkg::*;
(
    input  logic [15:0] word,
    output dec_t        dec
);
    logic [3:0] opc;
    logic       inv_form_ok;

    assign opc         = word[15:12];
    assign inv_form_ok = (word[5:0] == 6'b111111);

    always_comb begin
        dec.dst     = word[11:9];
        dec.src_a   = word[8:6];
        dec.src_b   = word[2:0];
        dec.use_imm = word[5];
        dec.imm     = sext_imm(word[IMM_W-1:0]);
        unique case (opc)
            OPC_ADD: dec.op = OP_ADD;
            OPC_AND: dec.op = OP_AND;
            OPC_INV: dec.op = inv_form_ok ? OP_INV : OP_NONE;
            default: dec.op = OP_NONE;
        endcase
        if (dec.op == OP_INV) dec.use_imm = 1'b0;
    end
endmodule

// File: rtl/gpr_file.sv
module gpr_file
    import alu_exec_pkg::*;
#(
    parameter int DW   = DATA_W,
    parameter int NREG = NUM_REG,
    localparam int AW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr_a,
    input  logic [AW-1:0] raddr_b,
    input  logic [AW-1:0] raddr_dbg,
    output logic [DW-1:0] rdata_a,
    output logic [DW-1:0] rdata_b,
    output logic [DW-1:0] rdata_dbg
);
    logic [DW-1:0] regs [NREG];

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)
                regs[i] <= '0;
            else if (we && (waddr == AW'(i)))
                regs[i] <= wdata;
        end
    end

    assign rdata_a   = regs[raddr_a];
    assign rdata_b   = regs[raddr_b];
    assign rdata_dbg = regs[raddr_dbg];

    // R7: a write is visible in its target register after the edge
    p_write_lands_r7: assert property (@(posedge clk) disable iff (rst)
        we |=> regs[$past(waddr)] == $past(wdata));
endmodule

// File: rtl/alu_core.sv
module alu_core
    import alu_exec_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  alu_op_e       op,
    input  logic [DW-1:0] opnd_a,
    input  logic [DW-1:0] opnd_b,
    output logic [DW-1:0] result
);
    always_comb begin
        unique case (op)
            OP_ADD:  result = opnd_a + opnd_b;
            OP_AND:  result = opnd_a & opnd_b;
            OP_INV:  result = ~opnd_a;
            default: result = '0;
        endcase
    end
endmodule

// File: rtl/alu_exec_stage.sv
module alu_exec_stage
    import alu_exec_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        instr_valid,
    input  logic [15:0] instr,
    input  logic [2:0]  dbg_sel,
    output logic [15:0] dbg_data,
    output logic        flag_n,
    output logic        flag_z,
    output logic        flag_p
);
    logic [15:0]       ir;
    logic              ir_valid;
    dec_t              dec;
    logic [DATA_W-1:0] rd_a, rd_b, opnd_b, result;
    logic              wr_en;
    cc_t               cc;

    // instruction capture stage
    always_ff @(posedge clk) begin
        if (rst) begin
            ir_valid <= 1'b0;
            ir       <= '0;
        end else begin
            ir_valid <= instr_valid;
            if (instr_valid) ir <= instr;
        end
    end

    alu_decode u_dec (
        .word (ir),
        .dec  (dec)
    );

    gpr_file #(.DW(DATA_W), .NREG(NUM_REG)) u_gpr (
        .clk       (clk),
        .rst       (rst),
        .we        (wr_en),
        .waddr     (dec.dst),
        .wdata     (result),
        .raddr_a   (dec.src_a),
        .raddr_b   (dec.src_b),
        .raddr_dbg (dbg_sel),
        .rdata_a   (rd_a),
        .rdata_b   (rd_b),
        .rdata_dbg (dbg_data)
    );

    assign opnd_b = dec.use_imm ? dec.imm : rd_b;

    alu_core #(.DW(DATA_W)) u_alu (
        .op     (dec.op),
        .opnd_a (rd_a),
        .opnd_b (opnd_b),
        .result (result)
    );

    assign wr_en = ir_valid && (dec.op != OP_NONE);

    always_ff @(posedge clk) begin
        if (rst)        cc <= CC_RESET;
        else if (wr_en) cc <= cc_from(result);
    end

    assign flag_n = cc.n;
    assign flag_z = cc.z;
    assign flag_p = cc.p;

    // R6: exactly one condition flag set
    p_flags_onehot_r6: assert property (@(posedge clk) disable iff (rst)
        $countones({flag_n, flag_z, flag_p}) == 1);

    // R6: flags describe the value just written
    p_flags_track_r6: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (flag_n == $past(result[DATA_W-1])) &&
                  (flag_z == ($past(result) == '0)));

    // R8: no write, flags hold
    p_idle_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable({flag_n, flag_z, flag_p}));

    // R7: a strobed word is in execution on the following cycle
    p_capture_r7: assert property (@(posedge clk) disable iff (rst)
        instr_valid |=> ir_valid);

    // R1: zero flag set straight after reset
    p_reset_z_r1: assert property (@(posedge clk)
        $fell(rst) |-> (flag_z && !flag_n && !flag_p));
endmodule

// File: tb/tb_alu_exec_stage.sv
module tb_alu_exec_stage;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        instr_valid = 1'b0;
    logic [15:0] instr = '0;
    logic [2:0]  dbg_sel = '0;
    logic [15:0] dbg_data;
    logic        flag_n, flag_z, flag_p;

    int tests = 0;
    int fails = 0;
    bit done  = 0;

    logic [15:0] model [8];
    logic [2:0]  mflags;   // {n,z,p}

    always #2.5 clk = ~clk;

    alu_exec_stage dut (
        .clk(clk), .rst(rst), .instr_valid(instr_valid), .instr(instr),
        .dbg_sel(dbg_sel), .dbg_data(dbg_data),
        .flag_n(flag_n), .flag_z(flag_z), .flag_p(flag_p)
    );

    function automatic logic [15:0] w_rr(input logic [3:0] op, input int d, input int a,
                                         input int b, input logic [1:0] junk);
        return {op, 3'(d), 3'(a), 1'b0, junk, 3'(b)};
    endfunction
    function automatic logic [15:0] w_ri(input logic [3:0] op, input int d, input int a,
                                         input logic [4:0] imm);
        return {op, 3'(d), 3'(a), 1'b1, imm};
    endfunction
    function automatic logic [2:0] fl_of(input logic [15:0] v);
        return v[15] ? 3'b100 : (v == 0) ? 3'b010 : 3'b001;
    endfunction

    task automatic check(input string tag, input string what, input logic [15:0] act,
                         input logic [15:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic check_state(input string tag);
        for (int r = 0; r < 8; r++) begin
            dbg_sel = 3'(r);
            #0.1;
            check(tag, $sformatf("R%0d", r), dbg_data, model[r]);
        end
        check(tag, "flags", {13'b0, flag_n, flag_z, flag_p}, {13'b0, mflags});
    endtask

    // drive at a negedge; captured at next posedge, executed one edge later
    task automatic issue(input logic [15:0] w);
        @(negedge clk); instr = w; instr_valid = 1'b1;
        @(negedge clk); instr_valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic put(input int d, input logic [15:0] v);
        model[d] = v; mflags = fl_of(v);
    endtask

    task automatic t_reset;
        for (int r = 0; r < 8; r++) model[r] = '0;
        mflags = 3'b010;
        check_state("R1");
    endtask

    task automatic t_add_imm;
        issue(w_ri(4'b0001, 1, 0, 5'b01111)); put(1, 16'h000F);   // +15
        check_state("R3");
        issue(w_ri(4'b0001, 2, 0, 5'b10000)); put(2, 16'hFFF0);   // -16
        check_state("R3");
        issue(w_ri(4'b0001, 3, 1, 5'b11111)); put(3, 16'h000E);   // -1
        check_state("R3");
    endtask

    task automatic t_add_reg;
        issue(w_rr(4'b0001, 4, 1, 2, 2'b11)); put(4, 16'hFFFF);   // bits 4:3 set, ignored
        check_state("R2");
        issue(w_rr(4'b0001, 5, 4, 4, 2'b01)); put(5, 16'hFFFE);
        check_state("R2");
        issue(w_rr(4'b0001, 6, 4, 1, 2'b00)); put(6, 16'h000E);   // wraps mod 2^16
        check_state("R2");
    endtask

    task automatic t_and;
        issue(w_rr(4'b0101, 6, 4, 1, 2'b10)); put(6, 16'h000F);
        check_state("R4");
        issue(w_ri(4'b0101, 6, 4, 5'b00000)); put(6, 16'h0000);   // zero result
        check_state("R4");
        issue(w_ri(4'b0101, 7, 5, 5'b11000)); put(7, 16'hFFF8);   // -8 sign-extended
        check_state("R4");
    endtask

    task automatic t_not;
        issue({4'b1001, 3'd7, 3'd1, 6'b111111}); put(7, 16'hFFF0);
        check_state("R5");
        issue({4'b1001, 3'd7, 3'd7, 6'b111111}); put(7, 16'h000F);
        check_state("R5");
        issue({4'b1001, 3'd1, 3'd6, 6'b011111});                    // illegal
        check_state("R5");
        issue({4'b1001, 3'd1, 3'd6, 6'b111110});                    // illegal
        check_state("R5");
    endtask

    task automatic t_flags;
        issue(w_ri(4'b0101, 2, 2, 5'b00000)); put(2, 16'h0000);
        check(tagz(), "Z", {15'b0, flag_z}, 16'h1);
        issue(w_ri(4'b0001, 2, 2, 5'b10000)); put(2, 16'hFFF0);
        check("R6", "N", {15'b0, flag_n}, 16'h1);
        issue(w_ri(4'b0001, 2, 0, 5'b00001)); put(2, 16'h0001);
        check("R6", "P", {15'b0, flag_p}, 16'h1);
        check_state("R6");
    endtask

    function automatic string tagz();
        return "R6";
    endfunction

    task automatic t_timing;
        @(negedge clk); instr = w_ri(4'b0001, 0, 0, 5'b00101); instr_valid = 1'b1;
        @(negedge clk); instr_valid = 1'b0;   // capture edge passed
        dbg_sel = 3'd0; #0.1;
        check("R7", "R0 before exec edge", dbg_data, 16'h0000);
        check("R7", "flags before exec edge", {13'b0, flag_n, flag_z, flag_p}, {13'b0, mflags});
        @(negedge clk); put(0, 16'h0005);
        check_state("R7");
    endtask

    task automatic t_ignored;
        issue(w_ri(4'b0010, 3, 0, 5'b00111));      // unsupported opcode
        check_state("R8");
        issue(w_rr(4'b0000, 3, 0, 0, 2'b00));
        check_state("R8");
        @(negedge clk); instr = w_ri(4'b0001, 3, 3, 5'b00111); instr_valid = 1'b0;
        @(negedge clk); @(negedge clk);
        check_state("R8");
    endtask

    task automatic t_chain;
        @(negedge clk); instr = w_ri(4'b0001, 3, 3, 5'b00001); instr_valid = 1'b1;
        @(negedge clk); instr = w_ri(4'b0001, 3, 3, 5'b00001);
        @(negedge clk); instr = w_rr(4'b0001, 4, 3, 3, 2'b00);
        @(negedge clk); instr_valid = 1'b0;
        @(negedge clk);
        put(3, 16'h0010); put(4, 16'h0020);
        check_state("R9");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_add_imm();
        t_add_reg();
        t_and();
        t_not();
        t_flags();
        t_timing();
        t_ignored();
        t_chain();
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        t_reset();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule